// File: doc/BRIEF.md
# Pipelined First-Order Recursive Filter

This block evaluates the recursion y[n] = b[n] + c[n] + M·y[n-1] on a stream of signed samples, one sample per clock. M is a constant integer parameter and is generally not a power of two. The two inputs are first summed and registered in a feed-forward stage. That registered sum then enters a feedback loop that holds one state register. The multiply by M and the final add sit in a single register-to-register path, so the recurrence is exact.

A valid strobe travels alongside the data. State advances only on valid samples, and each result appears two cycles after its inputs. All arithmetic is two's complement and wraps modulo 2^W. A synchronous active-high reset returns the pipeline to zero.

Top module: `iir1_pipe`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge clears `y`, `out_vld` and the internal sum stage to zero.
- R2: `out_vld` equals the value `in_vld` had two rising edges earlier, as long as no reset intervenes.
- R3: For each valid sample n, `y` shows b[n] + c[n] + M·y[n-1] from the second rising edge after that sample was presented. y[n-1] is the previous valid result, or zero after reset.
- R4: With M = 1, after reset and with samples valid on every cycle, `y` reads 0 at relative cycles 0 and 1 and b0+c0 at cycle 2. At cycle k it reads the sum of b and c over samples 0..k-2.
- R5: The sum, the product and the accumulation all wrap modulo 2^W as W-bit two's-complement values, with no saturation.
- R6: A cycle whose sample is not valid leaves `y` unchanged at the point where that sample would have been folded in.
- R7: The values on `b` and `c` in a cycle with `in_vld` low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample on `b` and `c` is valid this cycle |
| b | input | W | First signed input sample |
| c | input | W | Second signed input sample |
| out_vld | output | 1 | `y` holds a newly produced result |
| y | output | W | Signed recursion output |

## Verification
In the same cycle, the sum stage can capture a new sample while the feedback loop folds in the previous one. A change of `in_vld` in either stage therefore decides, independently, whether each register moves. The bench provokes this with streams of back-to-back valid samples and with random gap patterns, and drives random values on `b` and `c` during gaps. A reference model works from a queue of presented samples and is compared with every output on every cycle. Four instances run side by side with M of 5, 1, 4 and 3, the last at 8 bits so that the values wrap.

// File: rtl/iir1_pipe.sv
module iir1_pipe #(
  parameter int W = 16,
  parameter int M = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  output logic                out_vld,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MW = W'(M);

  logic                mid_vld;
  logic signed [W-1:0] mid_sum;
  logic signed [W-1:0] acc;
  logic                acc_vld;
  logic signed [W-1:0] fb;

  // feed-forward stage: one adder, outside the loop
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_vld <= 1'b0;
      mid_sum <= '0;
    end else begin
      mid_vld <= in_vld;
      if (in_vld) mid_sum <= b + c;
    end
  end

  // feedback loop: multiply and add share one register-to-register path
  assign fb = acc * MW;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld <= 1'b0;
      acc     <= '0;
    end else begin
      acc_vld <= mid_vld;
      if (mid_vld) acc <= mid_sum + fb;
    end
  end

  assign y       = acc;
  assign out_vld = acc_vld;
endmodule

module iir1_pipe_chk #(
  parameter int W = 16,
  parameter int M = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_vld,
  input logic signed [W-1:0] b,
  input logic signed [W-1:0] c,
  input logic                mid_vld,
  input logic signed [W-1:0] mid_sum,
  input logic                out_vld,
  input logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] KM = W'(M);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (y == '0 && !out_vld && !mid_vld && mid_sum == '0));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 out_vld);

  assert_invalid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ##1 !out_vld);

  assert_recurrence_R3: assert property (@(posedge clk) disable iff (rst)
    mid_vld |=> y == W'($past(mid_sum) + $past(y) * KM));

  assert_hold_on_gap_R6: assert property (@(posedge clk) disable iff (rst)
    !mid_vld |=> $stable(y));

  assert_gap_inputs_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(mid_sum));

  assert_stage_sum_R5: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> mid_sum == W'($past(b) + $past(c)));
endmodule

bind iir1_pipe iir1_pipe_chk #(.W(W), .M(M)) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .b(b), .c(c),
  .mid_vld(mid_vld), .mid_sum(mid_sum), .out_vld(out_vld), .y(y)
);

// File: tb/iir1_pipe_tb.sv
`timescale 1ns/1ps
module iir1_pipe_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] b = '0, c = '0;
  logic signed [7:0]  b8, c8;
  assign b8 = b[7:0];
  assign c8 = c[7:0];

  always #5 clk = ~clk;

  logic ov5, ov1, ov4, ov3;
  logic signed [15:0] y5, y1, y4;
  logic signed [7:0]  y3;

  iir1_pipe #(.W(16), .M(5)) dut_i    (.clk(clk), .rst(rst), .in_vld(in_vld), .b(b),  .c(c),  .out_vld(ov5), .y(y5));
  iir1_pipe #(.W(16), .M(1)) dut_i_m1 (.clk(clk), .rst(rst), .in_vld(in_vld), .b(b),  .c(c),  .out_vld(ov1), .y(y1));
  iir1_pipe #(.W(16), .M(4)) dut_i_m4 (.clk(clk), .rst(rst), .in_vld(in_vld), .b(b),  .c(c),  .out_vld(ov4), .y(y4));
  iir1_pipe #(.W(8),  .M(3)) dut_i_w8 (.clk(clk), .rst(rst), .in_vld(in_vld), .b(b8), .c(c8), .out_vld(ov3), .y(y3));

  int checks = 0, fails = 0;
  string tag = "R1";

  bit     qv[$];
  longint qs[$];
  longint qs8[$];
  logic signed [15:0] e5 = '0, e1 = '0, e4 = '0;
  logic signed [7:0]  e3 = '0;
  bit ev = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      qv.delete(); qs.delete(); qs8.delete();
      e5 = '0; e1 = '0; e4 = '0; e3 = '0; ev = 1'b0;
    end else begin
      qv.push_back(in_vld);
      qs.push_back(longint'(b) + longint'(c));
      qs8.push_back(longint'(b8) + longint'(c8));
      if (qv.size() == 2) begin
        bit v;
        longint s, s8;
        v = qv.pop_front(); s = qs.pop_front(); s8 = qs8.pop_front();
        ev = v;
        if (v) begin
          e5 = 16'(s + 5 * longint'(e5));
          e1 = 16'(s + longint'(e1));
          e4 = 16'(s + 4 * longint'(e4));
          e3 = 8'(s8 + 3 * longint'(e3));
        end
      end
    end
  end

  task automatic chk(string t, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", t, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(tag, "y M=5",  y5, e5);
      chk(tag, "y M=1",  y1, e1);
      chk(tag, "y M=4",  y4, e4);
      chk(tag, "y W=8",  y3, e3);
      chk("R2", "out_vld", {ov5, ov1, ov4, ov3}, {4{ev}});
    end
  end

  task automatic drive(bit v, logic signed [15:0] bb, logic signed [15:0] cc);
    @(posedge clk); #2;
    in_vld = v; b = bb; c = cc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset with activity on inputs
    for (int i = 0; i < 3; i++) drive(1, 16'(i * 77 + 5), 16'(i * 3 - 9));
    @(negedge clk);
    chk("R1", "y during reset", {y5, y1, y4, 8'(y3)}, 0);
    chk("R1", "out_vld during reset", {ov5, ov1, ov4, ov3}, 0);
    drive(0, 0, 0); rst = 1'b0;
    for (int i = 0; i < 3; i++) drive(0, 0, 0);

    // R4: M=1 start-up profile
    tag = "R4";
    drive(1, 16'sd10, 16'sd3);
    @(negedge clk); chk("R4", "cycle0 y M=1", y1, 0);
    drive(1, 16'sd7, -16'sd2);
    @(negedge clk); chk("R4", "cycle1 y M=1", y1, 0);
    drive(1, 16'sd100, 16'sd1);
    @(negedge clk); chk("R4", "cycle2 y M=1", y1, 13);
    drive(1, 16'sd4, 16'sd4);
    @(negedge clk); chk("R4", "cycle3 y M=1", y1, 18);
    drive(0, 0, 0);
    @(negedge clk); chk("R4", "cycle4 y M=1", y1, 119);

    // R3: back-to-back valid stream, small values
    tag = "R3";
    for (int i = 0; i < 200; i++)
      drive(1, 16'($urandom_range(0, 40)) - 16'sd20, 16'($urandom_range(0, 40)) - 16'sd20);

    // R6/R7: random gaps, junk on inputs in gaps
    tag = "R6";
    for (int i = 0; i < 300; i++) begin
      bit v = ($urandom_range(0, 2) != 0);
      if (v) drive(1, 16'($urandom_range(0, 30)), -16'($urandom_range(0, 30)));
      else   drive(0, 16'($urandom), 16'($urandom));
    end
    tag = "R7";
    drive(1, 16'sd9, 16'sd9);
    drive(0, 16'sh7fff, 16'sh7fff);
    drive(0, -16'sd1234, 16'sd555);
    drive(0, 0, 0);
    drive(0, 0, 0);
    @(negedge clk);
    chk("R7", "y M=1 after gap junk", y1, e1);
    chk("R6", "out_vld low in gap", ov1, 0);

    // R5: full-range values to force wrap
    tag = "R5";
    for (int i = 0; i < 200; i++) drive(1, 16'($urandom), 16'($urandom));
    drive(1, 16'sh7fff, 16'sh7fff);
    drive(1, -16'sh8000, -16'sh8000);

    // R1: mid-run reset
    drive(1, 16'sd5, 16'sd5);
    rst = 1'b1;
    drive(1, 16'sd5, 16'sd5);
    @(negedge clk);
    chk("R1", "y after mid-run reset", {y5, y1, y4, 8'(y3)}, 0);
    chk("R1", "out_vld after mid-run reset", {ov5, ov1, ov4, ov3}, 0);
    drive(0, 0, 0); rst = 1'b0;
    tag = "R3";
    for (int i = 0; i < 50; i++) drive(1, 16'(i), 16'(2 * i));
    drive(0, 0, 0); drive(0, 0, 0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule